// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline Sequencer

This block moves instruction tags through a four-stage in-order pipeline. The stages are, in order: fetch, decode, operand fetch, and execute. The execute stage covers both the ALU operation and the writeback. An instruction source offers one instruction per cycle. Each instruction carries a valid flag, a 3-bit class and a tag. The block accepts the instruction when its ready output is high. The occupant of every stage is visible on the outputs. When an instruction completes execute, a retire strobe reports its tag. No datapath is modelled: there is no ALU, no register file and no memory. The block only decides which instruction sits where and when the pipeline stalls.

Every instruction passes through every stage. Instructions of every class other than load and store complete execute in a single cycle. A load or a store stays in execute for a second cycle so that it can reach memory. During that extra cycle, the three stages behind execute keep their contents and ready drops, so the source must hold its instruction. When nothing stalls, the pipeline takes in one instruction per cycle and retires one per cycle once it is full.

Top module: `pipe4_sequencer`

## Requirements
- R1: A synchronous active-high reset empties all four stages. Each stage then has valid 0, class 0 and tag 0. After reset, retire_valid is 0 and in_ready is 1.
- R2: An instruction is accepted when in_valid and in_ready are both high at a clock edge. It then appears in fetch after that edge with its class and tag. A cycle with no accepted instruction puts a bubble in fetch. A bubble has valid 0, class 0 and tag 0. Class codes are: 0 nop, 1 arithmetic, 2 branch, 3 load, 4 store.
- R3: When in_ready is high, each stage passes its occupant to the next stage at the clock edge. The order is fetch to decode, decode to operand fetch, and operand fetch to execute. Bubbles move in the same way.
- R4: An instruction whose class is not 3 or 4 spends one cycle in execute. retire_valid is high during that cycle, with retire_tag equal to its tag. An instruction accepted at edge k therefore retires in the cycle after edge k+3.
- R5: A load (class 3) or a store (class 4) spends two consecutive cycles in execute. retire_valid is low during the first of these cycles and high during the second.
- R6: While a load or store is in its first execute cycle, in_ready is low. At the next edge, fetch, decode and operand fetch keep their contents, and in_valid, in_class and in_tag are ignored.
- R7: After the second execute cycle of a load or store, the occupant of operand fetch moves into execute. The stall therefore costs exactly one cycle with no retirement.
- R8: retire_valid is high for exactly one cycle for each accepted instruction. Tags retire in the order in which they were accepted, and a bubble never retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered by the source |
| in_class | input | 3 | Class of the offered instruction (0 nop, 1 arith, 2 branch, 3 load, 4 store) |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_ready | output | 1 | Pipeline can accept an instruction this cycle |
| stg_valid | output | 4 | Occupancy per stage; bit 0 fetch, bit 3 execute |
| stg_class | output | 12 | Class per stage, 3 bits each, stage k at bits 3k+2:3k |
| stg_tag | output | 4*TAG_W | Tag per stage, stage k at bits TAG_W*k+TAG_W-1:TAG_W*k |
| retire_valid | output | 1 | An instruction completes execute this cycle |
| retire_tag | output | TAG_W | Tag of the completing instruction |

## Verification
The bench targets several corner cases. The first is back-to-back loads and stores, where each stall must release before the next one begins. A design that stalls too long or too briefly here shows up as a missing retirement or a duplicated one. The second is a source that keeps in_valid high while ready is low. A design that ignores ready would overwrite fetch or lose a tag. The third is reset asserted in the middle of a stall. A design that keeps the second-cycle flag across reset would either drop ready or retire a stale tag. The fourth is a long stretch of random class and valid patterns, which checks every stage against a reference model on every cycle.

// File: rtl/pipe4_sequencer.sv
module pipe4_sequencer #(
  parameter int TAG_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2:0]           in_class,
  input  logic [TAG_W-1:0]     in_tag,
  output logic                 in_ready,
  output logic [3:0]           stg_valid,
  output logic [11:0]          stg_class,
  output logic [4*TAG_W-1:0]   stg_tag,
  output logic                 retire_valid,
  output logic [TAG_W-1:0]     retire_tag
);
  localparam int NSTG = 4;
  localparam int EX = NSTG - 1;
  localparam logic [2:0] CLS_NOP   = 3'd0;
  localparam logic [2:0] CLS_LOAD  = 3'd3;
  localparam logic [2:0] CLS_STORE = 3'd4;

  logic [NSTG-1:0] vld_q;
  logic [2:0]      cls_q [NSTG];
  logic [TAG_W-1:0] tag_q [NSTG];
  logic            second_q;

  wire ex_mem = vld_q[EX] && (cls_q[EX] == CLS_LOAD || cls_q[EX] == CLS_STORE);
  wire stall  = ex_mem && !second_q;
  wire take   = in_valid && !stall;

  assign in_ready     = !stall;
  assign retire_valid = vld_q[EX] && !stall;
  assign retire_tag   = tag_q[EX];
  assign stg_valid    = vld_q;

  for (genvar k = 0; k < NSTG; k++) begin : g_out
    assign stg_class[3*k +: 3]       = cls_q[k];
    assign stg_tag[TAG_W*k +: TAG_W] = tag_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      second_q <= 1'b0;
      for (int k = 0; k < NSTG; k++) begin
        cls_q[k] <= CLS_NOP;
        tag_q[k] <= '0;
      end
    end else if (stall) begin
      second_q <= 1'b1;
    end else begin
      second_q <= 1'b0;
      vld_q    <= {vld_q[NSTG-2:0], take};
      cls_q[0] <= take ? in_class : CLS_NOP;
      tag_q[0] <= take ? in_tag : '0;
      for (int k = 1; k < NSTG; k++) begin
        cls_q[k] <= cls_q[k-1];
        tag_q[k] <= tag_q[k-1];
      end
    end
  end
endmodule

// File: rtl/pipe4_sequencer_chk.sv
module pipe4_sequencer_chk #(
  parameter int TAG_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [2:0]         in_class,
  input logic [TAG_W-1:0]   in_tag,
  input logic               in_ready,
  input logic [3:0]         stg_valid,
  input logic [11:0]        stg_class,
  input logic [4*TAG_W-1:0] stg_tag,
  input logic               retire_valid,
  input logic [TAG_W-1:0]   retire_tag
);
  wire ex_mem = stg_valid[3] && (stg_class[11:9] == 3'd3 || stg_class[11:9] == 3'd4);
  wire [TAG_W-1:0] ex_tag = stg_tag[3*TAG_W +: TAG_W];

  AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (stg_valid == 4'b0 && !retire_valid && in_ready)); // R1
  AST_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (stg_valid[0] && stg_tag[TAG_W-1:0] == $past(in_tag))); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (in_ready && stg_valid[2]) |=> (stg_valid[3] && ex_tag == $past(stg_tag[2*TAG_W +: TAG_W]))); // R3
  AST_SINGLE_EX: assert property (@(posedge clk) disable iff (rst)
    (stg_valid[3] && !ex_mem) |-> (retire_valid && in_ready && retire_tag == ex_tag)); // R4
  AST_MEM_FIRST: assert property (@(posedge clk) disable iff (rst)
    (ex_mem && !in_ready) |-> !retire_valid); // R5
  AST_MEM_SECOND: assert property (@(posedge clk) disable iff (rst)
    (ex_mem && !in_ready) |=> (stg_valid[3] && $stable(ex_tag) && retire_valid && in_ready)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> ($stable(stg_valid[2:0]) && $stable(stg_tag[3*TAG_W-1:0]) && $stable(stg_class[8:0]))); // R6
  AST_RETIRE_REAL: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> stg_valid[3]); // R8
endmodule

bind pipe4_sequencer pipe4_sequencer_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/tb_pipe4_sequencer.sv
module tb_pipe4_sequencer;
  localparam int TAG_W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_class = 3'd0;
  logic [TAG_W-1:0] in_tag = '0;
  logic in_ready, retire_valid;
  logic [3:0] stg_valid;
  logic [11:0] stg_class;
  logic [4*TAG_W-1:0] stg_tag;
  logic [TAG_W-1:0] retire_tag;

  pipe4_sequencer #(.TAG_W(TAG_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit v; int c; int t; } slot_t;
  slot_t pipe[$];
  int order_q[$];
  bit sec = 0;
  int compared = 0, mismatched = 0;
  int next_tag = 1;

  function automatic bit is_mem(int c); return c == 3 || c == 4; endfunction

  task automatic clear_model();
    slot_t b = '{0, 0, 0};
    pipe.delete();
    for (int i = 0; i < 4; i++) pipe.push_back(b);
    order_q.delete();
    sec = 0;
  endtask

  task automatic fail(string req, string what, int act, int exp);
    mismatched++;
    $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
  endtask

  function automatic bit m_stall();
    return pipe[3].v && is_mem(pipe[3].c) && !sec;
  endfunction

  task automatic compare();
    bit st = m_stall();
    compared++;
    for (int k = 0; k < 4; k++) begin
      string rq = (k == 0) ? "R2" : (k == 3) ? "R7" : "R3";
      if (stg_valid[k] !== pipe[k].v) fail(rq, $sformatf("stage%0d valid", k), stg_valid[k], pipe[k].v);
      if (int'(stg_class[3*k +: 3]) != pipe[k].c) fail(rq, $sformatf("stage%0d class", k), stg_class[3*k +: 3], pipe[k].c);
      if (int'(stg_tag[TAG_W*k +: TAG_W]) != pipe[k].t) fail(rq, $sformatf("stage%0d tag", k), stg_tag[TAG_W*k +: TAG_W], pipe[k].t);
    end
    if (in_ready !== !st) fail("R6", "in_ready", in_ready, !st);
    if (retire_valid !== (pipe[3].v && !st))
      fail(is_mem(pipe[3].c) ? "R5" : "R4", "retire_valid", retire_valid, pipe[3].v && !st);
    if (retire_valid === 1'b1) begin
      if (order_q.size() == 0) fail("R8", "retire with nothing pending", retire_tag, -1);
      else begin
        int e = order_q.pop_front();
        if (int'(retire_tag) != e) fail("R8", "retire order tag", retire_tag, e);
      end
    end
  endtask

  task automatic step(bit r, bit v, int c);
    rst = r; in_valid = v; in_class = 3'(c); in_tag = TAG_W'(next_tag);
    @(posedge clk);
    if (r) clear_model();
    else if (m_stall()) sec = 1;
    else begin
      slot_t s = v ? '{1, c, next_tag & ((1 << TAG_W) - 1)} : '{0, 0, 0};
      if (v) order_q.push_back(s.t);
      sec = 0;
      pipe.push_front(s);
      void'(pipe.pop_back());
      if (v) next_tag++;
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    fail("WATCHDOG", "run did not finish", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clear_model();
    @(negedge clk);
    step(1, 1, 1);
    step(1, 0, 0);
    // R1: reset state
    compared++;
    if (stg_valid !== 4'b0 || retire_valid !== 1'b0 || in_ready !== 1'b1)
      fail("R1", "reset state valid/retire/ready", {stg_valid, retire_valid, in_ready}, 1);
    // R4: arithmetic stream with gaps, latency of four cycles
    for (int i = 0; i < 10; i++) step(0, (i % 3) != 2, 1 + (i % 2));
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    // R5 R6: arith, load, arith, arith, branch, nop with source holding valid during stalls
    begin
      int seq[6] = '{1, 3, 1, 1, 2, 0};
      for (int i = 0; i < 6; i++) begin
        step(0, 1, seq[i]);
        while (!in_ready) step(0, 1, seq[i]);
      end
    end
    for (int i = 0; i < 6; i++) step(0, 0, 0);
    // R5 R7: back-to-back loads and stores
    for (int i = 0; i < 12; i++) begin
      int c = (i % 2) ? 4 : 3;
      step(0, 1, c);
      while (!in_ready) step(0, 1, c);
    end
    for (int i = 0; i < 8; i++) step(0, 0, 0);
    // R1: reset in the middle of a stall
    step(0, 1, 1); step(0, 1, 1); step(0, 1, 3); step(0, 1, 1); step(0, 1, 1);
    while (in_ready) step(0, 1, 1);
    step(1, 1, 4);
    step(0, 0, 0);
    // R2 R3 R8: random valid/class pattern, inputs changing even while stalled
    for (int i = 0; i < 600; i++) step(0, ($urandom % 4) != 0, $urandom % 5);
    for (int i = 0; i < 8; i++) step(0, 0, 0);
    compared++;
    if (order_q.size() != 0) fail("R8", "instructions never retired", order_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule